// File: doc/BRIEF.md
# Thread Block Dispatcher with Occupancy Limits

This block takes one kernel launch at a time and hands out its thread blocks to a configurable number of multiprocessors. A launch descriptor gives the number of blocks in the grid, the threads in each block, the registers each thread needs and the shared memory each block needs. Each multiprocessor has four budgets: resident threads, resident blocks, a register pool and a shared-memory pool. A block goes to a multiprocessor only if all four budgets can take the whole block at once. Resources are charged and returned in whole-block units only.

Blocks leave in ascending block index. The target is the lowest-indexed multiprocessor that can accept the block. Each dispatch is offered on a valid/ready handshake. When no multiprocessor has room, the next block waits. It goes out once a completion report frees enough room. A completion names the multiprocessor and carries the size of the finished block. The dispatcher raises a done flag when every block of the grid has been both dispatched and completed. A descriptor whose single block could never fit on any multiprocessor is refused with an error flag, so the launch cannot wait forever.

Top module: `blk_dispatcher`

## Requirements
- R1: A multiprocessor never holds more than 1536 resident threads. Blocks are placed on it only while the thread total stays within that limit.
- R2: A multiprocessor never holds more than 8 resident blocks, whatever their size.
- R3: A block charges threads × registers-per-thread against a pool of 16384 registers per multiprocessor. For example, 256 threads at 10 registers charge 2560. A multiprocessor never exceeds the pool.
- R4: A block charges its shared-memory size against a pool of 49152 units per multiprocessor. A multiprocessor never exceeds the pool.
- R5: A block is sent to the lowest-indexed multiprocessor whose four budgets can all hold it. With no completions, multiprocessor 0 therefore fills before multiprocessor 1, and so on.
- R6: While `disp_valid` is high and `disp_ready` is low, `disp_valid`, `disp_sm` and `disp_block` stay unchanged in the next cycle.
- R7: Block indices are dispatched in ascending order starting at 0, one per accepted handshake.
- R8: A completion is credited at the clock edge where `cpl_valid` is sampled. A block that was waiting for that room is offered in the cycle right after, to the multiprocessor that completed.
- R9: `kernel_done` rises once all blocks are dispatched and completed. It stays high until the next launch is accepted. A launch with zero blocks sets it at once.
- R10: A launch is refused with `launch_err` high and nothing is dispatched if any of these holds:
    - the block size is 0;
    - the block size is above 1024 threads;
    - the block size is above 1536 threads;
    - threads × registers-per-thread is above 16384;
    - the shared memory is above 49152.

  `launch_err` clears when the next launch is accepted.
- R11: `launch_ready` is high only while no launch is in progress. It is high after reset, with `disp_valid`, `kernel_done` and `launch_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Launch descriptor present |
| launch_ready | output | 1 | Dispatcher idle and able to take a launch |
| launch_blocks | input | GRID_W | Blocks in the grid |
| launch_threads | input | THR_W | Threads per block |
| launch_rpt | input | RPT_W | Registers per thread |
| launch_smem | input | SMEM_W | Shared memory per block |
| disp_valid | output | 1 | A block is offered |
| disp_ready | input | 1 | Downstream takes the offered block |
| disp_sm | output | SM_W | Target multiprocessor index |
| disp_block | output | GRID_W | Index of the offered block |
| cpl_valid | input | 1 | A block finished |
| cpl_sm | input | SM_W | Multiprocessor that finished the block |
| cpl_threads | input | THR_W | Threads of the finished block |
| cpl_rpt | input | RPT_W | Registers per thread of the finished block |
| cpl_smem | input | SMEM_W | Shared memory of the finished block |
| kernel_done | output | 1 | Every block dispatched and completed |
| launch_err | output | 1 | Last launch refused as oversize |

## Verification
The hardest state to reach from the ports is full saturation. Every multiprocessor sits exactly at its binding limit, and a block is still waiting. The bench gets there by sweeping descriptors and computing, for each one, the per-multiprocessor capacity as the minimum of the four budget quotients. It then launches a grid two blocks larger than the total capacity and withholds all completions until the fill pattern and the stall are checked. Targeted completions then release one block at a time. One of them is issued with the downstream stalled, so the waiting offer and its hold are both observed before the grid is drained.

// File: rtl/tbd_pkg.sv
// Shared types for the thread block dispatcher.
// Assumes: one kernel launch in progress at a time.
package tbd_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/tbd_sm_budget.sv
// Resource ledger for one multiprocessor.
// Tracks resident threads, blocks, registers and shared memory.
// Reports whether the current block demand fits all four budgets at once.
// Assumes: completions only return resources that were earlier charged.
// A charge and a release may land in the same cycle.
module tbd_sm_budget #(
    parameter int MAX_THREADS = 1536,
    parameter int MAX_BLOCKS  = 8,
    parameter int REG_POOL    = 16384,
    parameter int SMEM_POOL   = 49152,
    parameter int THR_W       = 11,
    parameter int REQ_W       = 19,
    parameter int SMEM_W      = 16,
    parameter int TU_W        = $clog2(MAX_THREADS + 1),
    parameter int BU_W        = $clog2(MAX_BLOCKS + 1),
    parameter int RU_W        = $clog2(REG_POOL + 1),
    parameter int SU_W        = $clog2(SMEM_POOL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [THR_W-1:0]  need_thr,
    input  logic [REQ_W-1:0]  need_reg,
    input  logic [SMEM_W-1:0] need_smem,
    input  logic              alloc,
    input  logic              rel_en,
    input  logic [THR_W-1:0]  rel_thr,
    input  logic [REQ_W-1:0]  rel_reg,
    input  logic [SMEM_W-1:0] rel_smem,
    output logic              fits,
    output logic [TU_W-1:0]   thr_used,
    output logic [BU_W-1:0]   blk_used,
    output logic [RU_W-1:0]   reg_used,
    output logic [SU_W-1:0]   smem_used
);
    logic [31:0] thr_nx, blk_nx, reg_nx, smem_nx;

    // Admission test: every budget must hold the whole block.
    always_comb begin
        fits = (32'(thr_used) + 32'(need_thr) <= 32'(MAX_THREADS)) &&
               (32'(blk_used) < 32'(MAX_BLOCKS)) &&
               (32'(reg_used) + 32'(need_reg) <= 32'(REG_POOL)) &&
               (32'(smem_used) + 32'(need_smem) <= 32'(SMEM_POOL));
    end

    // Next ledger values: add the granted block, subtract the finished one.
    always_comb begin
        thr_nx  = 32'(thr_used) + (alloc ? 32'(need_thr) : 32'd0)
                - (rel_en ? 32'(rel_thr) : 32'd0);
        blk_nx  = 32'(blk_used) + (alloc ? 32'd1 : 32'd0)
                - (rel_en ? 32'd1 : 32'd0);
        reg_nx  = 32'(reg_used) + (alloc ? 32'(need_reg) : 32'd0)
                - (rel_en ? 32'(rel_reg) : 32'd0);
        smem_nx = 32'(smem_used) + (alloc ? 32'(need_smem) : 32'd0)
                - (rel_en ? 32'(rel_smem) : 32'd0);
    end

    // Ledger registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_used  <= '0;
            blk_used  <= '0;
            reg_used  <= '0;
            smem_used <= '0;
        end else begin
            thr_used  <= TU_W'(thr_nx);
            blk_used  <= BU_W'(blk_nx);
            reg_used  <= RU_W'(reg_nx);
            smem_used <= SU_W'(smem_nx);
        end
    end
endmodule

// File: rtl/tbd_lowest_pick.sv
// Fixed-priority picker: returns the lowest set bit index of a request vector.
// Assumes: the index is ignored when no request is set.
module tbd_lowest_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    // Scan from high to low so the lowest request wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/tbd_launch_ctrl.sv
// Launch sequencer.
// Validates and latches the descriptor, counts issued and completed blocks,
// and raises the done and error flags.
// Assumes: completions arrive only for blocks of the running launch.
module tbd_launch_ctrl
    import tbd_pkg::*;
#(
    parameter int GRID_W          = 16,
    parameter int THR_W           = 11,
    parameter int RPT_W           = 8,
    parameter int SMEM_W          = 16,
    parameter int REQ_W           = 19,
    parameter int MAX_BLK_THREADS = 1024,
    parameter int MAX_THREADS     = 1536,
    parameter int REG_POOL        = 16384,
    parameter int SMEM_POOL       = 49152
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_valid,
    input  logic [GRID_W-1:0] launch_blocks,
    input  logic [THR_W-1:0]  launch_threads,
    input  logic [RPT_W-1:0]  launch_rpt,
    input  logic [SMEM_W-1:0] launch_smem,
    input  logic              disp_fire,
    input  logic              cpl_valid,
    output logic              launch_ready,
    output logic [THR_W-1:0]  need_thr,
    output logic [REQ_W-1:0]  need_reg,
    output logic [SMEM_W-1:0] need_smem,
    output logic [GRID_W-1:0] next_blk,
    output logic              blk_pending,
    output logic              kernel_done,
    output logic              launch_err
);
    run_state_e        state;
    logic [GRID_W-1:0] grid_q, cmp_q, issued_nx, cmp_nx;
    logic [REQ_W-1:0]  req_reg;
    logic              bad_desc;

    // Oversize test for a single block against one multiprocessor's budgets.
    always_comb begin
        req_reg  = REQ_W'(launch_threads) * REQ_W'(launch_rpt);
        bad_desc = (launch_threads == '0) ||
                   (32'(launch_threads) > 32'(MAX_BLK_THREADS)) ||
                   (32'(launch_threads) > 32'(MAX_THREADS)) ||
                   (32'(req_reg) > 32'(REG_POOL)) ||
                   (32'(launch_smem) > 32'(SMEM_POOL));
    end

    // Progress counters after this cycle's handshake and completion.
    always_comb begin
        issued_nx = next_blk + GRID_W'(disp_fire);
        cmp_nx    = cmp_q + GRID_W'(cpl_valid);
    end

    // Launch state, descriptor latch, counters and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            grid_q      <= '0;
            next_blk    <= '0;
            cmp_q       <= '0;
            need_thr    <= '0;
            need_reg    <= '0;
            need_smem   <= '0;
            kernel_done <= 1'b0;
            launch_err  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch_valid) begin
                        launch_err  <= bad_desc;
                        kernel_done <= !bad_desc && (launch_blocks == '0);
                        if (!bad_desc && launch_blocks != '0) begin
                            state     <= ST_RUN;
                            grid_q    <= launch_blocks;
                            next_blk  <= '0;
                            cmp_q     <= '0;
                            need_thr  <= launch_threads;
                            need_reg  <= req_reg;
                            need_smem <= launch_smem;
                        end
                    end
                end
                ST_RUN: begin
                    next_blk <= issued_nx;
                    cmp_q    <= cmp_nx;
                    if (issued_nx == grid_q && cmp_nx == grid_q) begin
                        state       <= ST_IDLE;
                        kernel_done <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status seen by the top.
    always_comb begin
        launch_ready = (state == ST_IDLE);
        blk_pending  = (state == ST_RUN) && (next_blk != grid_q);
    end
endmodule

// File: rtl/blk_dispatcher.sv
// Thread block dispatcher.
// Hands the blocks of one launch, in ascending index, to the
// lowest-indexed multiprocessor whose budgets can all hold the block.
// An offer that is not yet taken holds its target.
// Assumes: completions carry the size of a block charged on cpl_sm.
module blk_dispatcher #(
    parameter int NUM_SM          = 4,
    parameter int MAX_THREADS     = 1536,
    parameter int MAX_BLOCKS      = 8,
    parameter int REG_POOL        = 16384,
    parameter int SMEM_POOL       = 49152,
    parameter int MAX_BLK_THREADS = 1024,
    parameter int GRID_W          = 16,
    parameter int RPT_W           = 8,
    parameter int THR_W           = $clog2(MAX_BLK_THREADS + 1),
    parameter int SMEM_W          = $clog2(SMEM_POOL + 1),
    parameter int SM_W            = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_valid,
    output logic              launch_ready,
    input  logic [GRID_W-1:0] launch_blocks,
    input  logic [THR_W-1:0]  launch_threads,
    input  logic [RPT_W-1:0]  launch_rpt,
    input  logic [SMEM_W-1:0] launch_smem,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [SM_W-1:0]   disp_sm,
    output logic [GRID_W-1:0] disp_block,
    input  logic              cpl_valid,
    input  logic [SM_W-1:0]   cpl_sm,
    input  logic [THR_W-1:0]  cpl_threads,
    input  logic [RPT_W-1:0]  cpl_rpt,
    input  logic [SMEM_W-1:0] cpl_smem,
    output logic              kernel_done,
    output logic              launch_err
);
    localparam int REQ_W = THR_W + RPT_W;
    localparam int TU_W  = $clog2(MAX_THREADS + 1);
    localparam int BU_W  = $clog2(MAX_BLOCKS + 1);
    localparam int RU_W  = $clog2(REG_POOL + 1);
    localparam int SU_W  = $clog2(SMEM_POOL + 1);

    logic [THR_W-1:0]       need_thr;
    logic [REQ_W-1:0]       need_reg, cpl_reg;
    logic [SMEM_W-1:0]      need_smem;
    logic                   blk_pending, any_fit, disp_fire;
    logic                   hold_q;
    logic [SM_W-1:0]        hold_sm_q, pick_sm;
    logic [NUM_SM-1:0]      fit_vec;
    logic [NUM_SM*TU_W-1:0] thr_used_flat;
    logic [NUM_SM*BU_W-1:0] blk_used_flat;
    logic [NUM_SM*RU_W-1:0] reg_used_flat;
    logic [NUM_SM*SU_W-1:0] smem_used_flat;

    tbd_launch_ctrl #(
        .GRID_W(GRID_W), .THR_W(THR_W), .RPT_W(RPT_W), .SMEM_W(SMEM_W),
        .REQ_W(REQ_W), .MAX_BLK_THREADS(MAX_BLK_THREADS),
        .MAX_THREADS(MAX_THREADS), .REG_POOL(REG_POOL), .SMEM_POOL(SMEM_POOL)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_blocks(launch_blocks),
        .launch_threads(launch_threads), .launch_rpt(launch_rpt),
        .launch_smem(launch_smem), .disp_fire(disp_fire),
        .cpl_valid(cpl_valid), .launch_ready(launch_ready),
        .need_thr(need_thr), .need_reg(need_reg), .need_smem(need_smem),
        .next_blk(disp_block), .blk_pending(blk_pending),
        .kernel_done(kernel_done), .launch_err(launch_err)
    );

    // Register demand of the finished block, shared by all ledgers.
    always_comb cpl_reg = REQ_W'(cpl_threads) * REQ_W'(cpl_rpt);

    for (genvar g = 0; g < NUM_SM; g++) begin : g_sm
        logic            alloc_g, rel_g;
        logic [TU_W-1:0] thr_u;
        logic [BU_W-1:0] blk_u;
        logic [RU_W-1:0] reg_u;
        logic [SU_W-1:0] smem_u;

        // Charge this ledger on a handshake aimed here, release on its completion.
        always_comb begin
            alloc_g = disp_fire && (disp_sm == SM_W'(g));
            rel_g   = cpl_valid && (cpl_sm == SM_W'(g));
        end

        tbd_sm_budget #(
            .MAX_THREADS(MAX_THREADS), .MAX_BLOCKS(MAX_BLOCKS),
            .REG_POOL(REG_POOL), .SMEM_POOL(SMEM_POOL),
            .THR_W(THR_W), .REQ_W(REQ_W), .SMEM_W(SMEM_W)
        ) u_budget (
            .clk(clk), .rst_n(rst_n),
            .need_thr(need_thr), .need_reg(need_reg), .need_smem(need_smem),
            .alloc(alloc_g), .rel_en(rel_g),
            .rel_thr(cpl_threads), .rel_reg(cpl_reg), .rel_smem(cpl_smem),
            .fits(fit_vec[g]),
            .thr_used(thr_u), .blk_used(blk_u), .reg_used(reg_u),
            .smem_used(smem_u)
        );

        assign thr_used_flat[g*TU_W +: TU_W]   = thr_u;
        assign blk_used_flat[g*BU_W +: BU_W]   = blk_u;
        assign reg_used_flat[g*RU_W +: RU_W]   = reg_u;
        assign smem_used_flat[g*SU_W +: SU_W]  = smem_u;
    end

    tbd_lowest_pick #(.N(NUM_SM), .W(SM_W)) u_pick (
        .req(fit_vec), .any(any_fit), .idx(pick_sm)
    );

    // Offer: a pending block with a held target or a fresh fitting one.
    always_comb begin
        disp_valid = blk_pending && (hold_q || any_fit);
        disp_sm    = hold_q ? hold_sm_q : pick_sm;
        disp_fire  = disp_valid && disp_ready;
    end

    // Freeze the target while an offer waits for the downstream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= 1'b0;
            hold_sm_q <= '0;
        end else begin
            hold_q    <= disp_valid && !disp_ready;
            hold_sm_q <= disp_sm;
        end
    end
endmodule

// File: rtl/tbd_checker.sv
// Property checker for blk_dispatcher, attached by bind.
// Checks the budget ceilings, handshake hold, issue order and quiet flags.
module tbd_checker #(
    parameter int NUM_SM      = 4,
    parameter int MAX_THREADS = 1536,
    parameter int MAX_BLOCKS  = 8,
    parameter int REG_POOL    = 16384,
    parameter int SMEM_POOL   = 49152,
    parameter int GRID_W      = 16,
    parameter int SM_W        = 2,
    parameter int TU_W        = $clog2(MAX_THREADS + 1),
    parameter int BU_W        = $clog2(MAX_BLOCKS + 1),
    parameter int RU_W        = $clog2(REG_POOL + 1),
    parameter int SU_W        = $clog2(SMEM_POOL + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   disp_valid,
    input logic                   disp_ready,
    input logic [SM_W-1:0]        disp_sm,
    input logic [GRID_W-1:0]      disp_block,
    input logic                   kernel_done,
    input logic                   launch_err,
    input logic                   launch_ready,
    input logic [NUM_SM*TU_W-1:0] thr_used_flat,
    input logic [NUM_SM*BU_W-1:0] blk_used_flat,
    input logic [NUM_SM*RU_W-1:0] reg_used_flat,
    input logic [NUM_SM*SU_W-1:0] smem_used_flat
);
    for (genvar g = 0; g < NUM_SM; g++) begin : g_cap
        AST_THR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            32'(thr_used_flat[g*TU_W +: TU_W]) <= 32'(MAX_THREADS)); // R1
        AST_BLK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            32'(blk_used_flat[g*BU_W +: BU_W]) <= 32'(MAX_BLOCKS)); // R2
        AST_REG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            32'(reg_used_flat[g*RU_W +: RU_W]) <= 32'(REG_POOL)); // R3
        AST_SMEM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            32'(smem_used_flat[g*SU_W +: SU_W]) <= 32'(SMEM_POOL)); // R4
    end

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=>
        (disp_valid && $stable(disp_sm) && $stable(disp_block))); // R6

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=>
        (!disp_valid || disp_block == $past(disp_block) + 1'b1)); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_done |-> (!disp_valid && launch_ready)); // R9

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        launch_err |-> (!disp_valid && launch_ready)); // R10
endmodule

bind blk_dispatcher tbd_checker #(
    .NUM_SM(NUM_SM), .MAX_THREADS(MAX_THREADS), .MAX_BLOCKS(MAX_BLOCKS),
    .REG_POOL(REG_POOL), .SMEM_POOL(SMEM_POOL), .GRID_W(GRID_W), .SM_W(SM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_sm(disp_sm), .disp_block(disp_block),
    .kernel_done(kernel_done), .launch_err(launch_err),
    .launch_ready(launch_ready),
    .thr_used_flat(thr_used_flat), .blk_used_flat(blk_used_flat),
    .reg_used_flat(reg_used_flat), .smem_used_flat(smem_used_flat)
);

// File: tb/tb_blk_dispatcher.sv
// Bench: sweeps block shapes on a three-multiprocessor dispatcher.
// Predicts the per-multiprocessor capacity from the four budget quotients.
module tb_blk_dispatcher;
    localparam int NSM    = 3;
    localparam int GRID_W = 16;
    localparam int THR_W  = 11;
    localparam int RPT_W  = 8;
    localparam int SMEM_W = 16;
    localparam int SM_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              launch_valid = 1'b0, launch_ready;
    logic [GRID_W-1:0] launch_blocks = '0;
    logic [THR_W-1:0]  launch_threads = '0;
    logic [RPT_W-1:0]  launch_rpt = '0;
    logic [SMEM_W-1:0] launch_smem = '0;
    logic              disp_valid, disp_ready = 1'b1;
    logic [SM_W-1:0]   disp_sm;
    logic [GRID_W-1:0] disp_block;
    logic              cpl_valid = 1'b0;
    logic [SM_W-1:0]   cpl_sm = '0;
    logic [THR_W-1:0]  cpl_threads = '0;
    logic [RPT_W-1:0]  cpl_rpt = '0;
    logic [SMEM_W-1:0] cpl_smem = '0;
    logic              kernel_done, launch_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    blk_dispatcher #(.NUM_SM(NSM)) dut (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_ready(launch_ready),
        .launch_blocks(launch_blocks), .launch_threads(launch_threads),
        .launch_rpt(launch_rpt), .launch_smem(launch_smem),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_sm(disp_sm), .disp_block(disp_block),
        .cpl_valid(cpl_valid), .cpl_sm(cpl_sm), .cpl_threads(cpl_threads),
        .cpl_rpt(cpl_rpt), .cpl_smem(cpl_smem),
        .kernel_done(kernel_done), .launch_err(launch_err)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch(input int g, input int t, input int r, input int s);
        launch_blocks  = GRID_W'(g);
        launch_threads = THR_W'(t);
        launch_rpt     = RPT_W'(r);
        launch_smem    = SMEM_W'(s);
        launch_valid   = 1'b1;
        @(posedge clk); #1;
        launch_valid   = 1'b0;
        @(negedge clk);
    endtask

    task automatic complete(input int sm, input int t, input int r, input int s);
        cpl_sm      = SM_W'(sm);
        cpl_threads = THR_W'(t);
        cpl_rpt     = RPT_W'(r);
        cpl_smem    = SMEM_W'(s);
        cpl_valid   = 1'b1;
        @(posedge clk); #1;
        cpl_valid   = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_cfg(input int t, input int r, input int s);
        int k, g, nk, q;
        string tag;
        k = 8; tag = "R2";
        q = 1536 / t;          if (q < k || (q == k && tag == "R2")) begin k = q; tag = "R1"; end
        q = 16384 / (t * r);   if (q < k) begin k = q; tag = "R3"; end
        if (s != 0) begin q = 49152 / s; if (q < k) begin k = q; tag = "R4"; end end
        nk = NSM * k;
        g  = nk + 2;
        disp_ready = 1'b1;
        launch(g, t, r, s);
        check(launch_err == 1'b0, "R10 err cleared", int'(launch_err), 0);
        check(launch_ready == 1'b0, "R11 busy", int'(launch_ready), 0);
        for (int i = 0; i < nk; i++) begin
            check(disp_valid == 1'b1, "R5 fill valid", int'(disp_valid), 1);
            check(int'(disp_sm) == i / k, "R5 lowest sm", int'(disp_sm), i / k);
            check(int'(disp_block) == i, "R7 block order", int'(disp_block), i);
            @(negedge clk);
        end
        check(disp_valid == 1'b0, {tag, " capacity stall"}, int'(disp_valid), 0);
        complete(NSM - 1, t, r, s);
        check(disp_valid == 1'b1, "R8 release valid", int'(disp_valid), 1);
        check(int'(disp_sm) == NSM - 1, "R8 release sm", int'(disp_sm), NSM - 1);
        check(int'(disp_block) == nk, "R8 release block", int'(disp_block), nk);
        @(negedge clk);
        disp_ready = 1'b0;
        complete(0, t, r, s);
        check(disp_valid == 1'b1 && disp_sm == '0, "R8 second release sm0",
              int'(disp_sm), 0);
        @(negedge clk);
        check(disp_valid == 1'b1, "R6 hold valid", int'(disp_valid), 1);
        check(disp_sm == '0 && int'(disp_block) == nk + 1, "R6 hold block",
              int'(disp_block), nk + 1);
        disp_ready = 1'b1;
        @(negedge clk);
        check(disp_valid == 1'b0, "R7 grid exhausted", int'(disp_valid), 0);
        for (int m = 0; m < NSM; m++) begin
            for (int j = 0; j < k; j++) begin
                if (m == NSM - 1 && j == k - 1)
                    check(kernel_done == 1'b0, "R9 not yet done", int'(kernel_done), 0);
                complete(m, t, r, s);
            end
        end
        check(kernel_done == 1'b1, "R9 done", int'(kernel_done), 1);
        check(launch_ready == 1'b1, "R11 idle after done", int'(launch_ready), 1);
    endtask

    task automatic err_cfg(input int t, input int r, input int s);
        launch(5, t, r, s);
        check(launch_err == 1'b1, "R10 refused", int'(launch_err), 1);
        check(disp_valid == 1'b0, "R10 no dispatch", int'(disp_valid), 0);
        @(negedge clk);
        check(disp_valid == 1'b0 && launch_ready == 1'b1, "R10 stays idle",
              int'(disp_valid), 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(launch_ready == 1'b1, "R11 reset ready", int'(launch_ready), 1);
        check(disp_valid == 1'b0, "R11 reset valid", int'(disp_valid), 0);
        check(kernel_done == 1'b0 && launch_err == 1'b0, "R11 reset flags",
              int'(kernel_done), 0);
        run_cfg(256, 10, 0);
        run_cfg(64, 4, 1024);
        run_cfg(128, 32, 0);
        run_cfg(32, 1, 20000);
        run_cfg(1024, 16, 0);
        run_cfg(1, 1, 0);
        run_cfg(512, 8, 0);
        run_cfg(32, 1, 49152);
        err_cfg(0, 1, 0);
        err_cfg(1025, 1, 0);
        err_cfg(1024, 17, 0);
        err_cfg(32, 1, 49153);
        run_cfg(96, 20, 4000);
        launch(0, 64, 1, 0);
        check(kernel_done == 1'b1 && launch_err == 1'b0, "R9 empty grid",
              int'(kernel_done), 1);
        check(disp_valid == 1'b0, "R9 empty grid quiet", int'(disp_valid), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule